// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and drives a single interrupt line to the processor. Software sets a 3-bit urgency for each source, a per-source enable mask, and a mode bit. The mode bit picks plain delivery, where urgencies are ignored, or prioritised nesting, where an eight-level in-service record holds back every request that is not strictly more urgent than the level being served.

Software reaches the block through a word-addressed register port with a write strobe, a read strobe and registered read data. In nesting mode, a read of the vector location returns the winning source number and marks that source's urgency level as in service. The handler ends with a write to the in-service location. That write retires only the most urgent level that is still marked, so nested handlers unwind from the innermost outward.

Top module: `nestIrqCtrl`

## Requirements
- R1: After reset all urgency fields, the control bits, the enable mask and the in-service record are zero, `irqOut` is low and `rdData` is zero.
- R2: Register map by word address. Source s has its urgency in bits [4(s%8)+2 : 4(s%8)] of address s/8, and the fourth bit of each nibble reads as zero. Address 8 holds the mode bits in [1:0]: bit 0 turns on nesting, and bit 1 is stored with no effect. Address 9 holds the enable mask, with bit s for source s. Address 10 holds the in-service record in [7:0]. Any other address reads zero. Read data appears on `rdData` at the clock edge that samples `rdEn` and holds until the next read.
- R3: With nesting off, `irqOut` is high in the same cycle exactly when some source has both its request and its enable bit high.
- R4: With nesting off, a read of address 11 returns the lowest-numbered enabled pending source and leaves the in-service record unchanged.
- R5: With nesting on, a read of address 11 returns the eligible source with the smallest urgency value. On a tie, the lowest source number wins.
- R6: With nesting on, a read of address 11 that finds an eligible source sets in-service bit k, where k is the urgency of the returned source. This happens at the same clock edge.
- R7: With nesting on, an enabled pending source is eligible only if the in-service record is empty or its urgency value is below the lowest set in-service bit. `irqOut` is high exactly when some source is eligible.
- R8: A write of non-zero data to address 10 clears only the lowest-numbered set in-service bit. For example, 0x09 becomes 0x08 and then 0x00.
- R9: A write of zero data to address 10 leaves the in-service record unchanged.
- R10: A read of address 11 with no eligible source returns 0 and does not change the in-service record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Word address of the register access |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| reqIn | input | 12 | Level request lines, one per source |
| irqOut | output | 1 | Interrupt line to the processor |

## Verification
`irqOut` is combinational from the stored state and `reqIn`, so the bench compares it in the same cycle the requests are applied, one nanosecond after the falling edge. Read data and all register side effects, including the in-service set on a vector read and the single-bit clear on a write, land at the next rising edge. The bench's behavioural model therefore advances at that edge, and `rdData` is compared one nanosecond later. Each observation is made away from any edge, and every cycle is compared, including the random phase.

// File: rtl/nestIrqPkg.sv
`timescale 1ns/1ps
package nestIrqPkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_INSERV  = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR  = 4'd11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PRIO, SEL_CTRL, SEL_ENABLE, SEL_INSERV, SEL_VECTOR
  } readSel_e;

  // strobes from the decode control to the datapath
  typedef struct packed {
    logic     wrPrio;
    logic     wrCtrl;
    logic     wrEnable;
    logic     wrInServ;
    logic     rdStrobe;
    logic     rdVector;
    readSel_e readSel;
    logic [2:0] prioReg;
  } strobes_t;
endpackage

// File: rtl/nestIrqDecode.sv
`timescale 1ns/1ps
module nestIrqDecode
  import nestIrqPkg::*;
#(
  parameter int NUM_PRIO_REGS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          strb
);
  always_comb begin
    strb          = '0;
    strb.readSel  = SEL_NONE;
    strb.rdStrobe = rdEn;
    strb.prioReg  = addr[2:0];
    if (!addr[3]) begin
      if (int'(addr[2:0]) < NUM_PRIO_REGS) begin
        strb.wrPrio  = wrEn;
        strb.readSel = SEL_PRIO;
      end
    end else begin
      case (addr)
        ADDR_CTRL: begin
          strb.wrCtrl  = wrEn;
          strb.readSel = SEL_CTRL;
        end
        ADDR_ENABLE: begin
          strb.wrEnable = wrEn;
          strb.readSel  = SEL_ENABLE;
        end
        ADDR_INSERV: begin
          strb.wrInServ = wrEn;
          strb.readSel  = SEL_INSERV;
        end
        ADDR_VECTOR: begin
          strb.rdVector = rdEn;
          strb.readSel  = SEL_VECTOR;
        end
        default: strb.readSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/nestIrqArb.sv
`timescale 1ns/1ps
module nestIrqArb #(
  parameter int NUM_SRC = 12,
  parameter int PRIO_W  = 3,
  localparam int LEVELS = 1 << PRIO_W,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic                      nestOn,
  input  logic [LEVELS-1:0]         inServ,
  output logic                      anyElig,
  output logic [IDX_W-1:0]          selIdx,
  output logic [PRIO_W-1:0]         selPrio
);
  logic              ceilHit;
  logic [PRIO_W-1:0] ceilVal;
  logic [PRIO_W-1:0] effPrio [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  // most urgent level currently in service
  always_comb begin
    ceilHit = 1'b0;
    ceilVal = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (inServ[l]) begin
        ceilHit = 1'b1;
        ceilVal = PRIO_W'(l);
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign effPrio[i] = nestOn ? prioFlat[i*PRIO_W +: PRIO_W] : '0;
    assign elig[i]    = pend[i] & ~(nestOn & ceilHit & (effPrio[i] >= ceilVal));
  end

  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    anyElig = 1'b0;
    selIdx  = '0;
    selPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!anyElig || effPrio[i] < selPrio)) begin
        anyElig = 1'b1;
        selIdx  = IDX_W'(i);
        selPrio = effPrio[i];
      end
    end
  end
endmodule

// File: rtl/nestIrqData.sv
`timescale 1ns/1ps
module nestIrqData
  import nestIrqPkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int FIELD_W   = 4,
  localparam int FIELDS_PR = DATA_W / FIELD_W,
  localparam int LEVELS    = 1 << PRIO_W,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [PRIO_W-1:0]         prioQ [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [1:0]                ctrlQ;
  logic [NUM_SRC-1:0]        enableQ;
  logic [LEVELS-1:0]         inServQ, inServNext;
  logic [DATA_W-1:0]         rdDataQ, rdNext, prioWord;
  logic                      nestOn, anyElig;
  logic [IDX_W-1:0]          selIdx;
  logic [PRIO_W-1:0]         selPrio;

  assign nestOn = ctrlQ[0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    localparam int REG_IDX = i / FIELDS_PR;
    localparam int BIT_POS = (i % FIELDS_PR) * FIELD_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioQ[i] <= '0;
      else if (strb.wrPrio && int'(strb.prioReg) == REG_IDX)
        prioQ[i] <= wrData[BIT_POS +: PRIO_W];
    end
    assign prioFlat[i*PRIO_W +: PRIO_W] = prioQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      enableQ <= '0;
    end else begin
      if (strb.wrCtrl)   ctrlQ   <= wrData[1:0];
      if (strb.wrEnable) enableQ <= wrData[NUM_SRC-1:0];
    end
  end

  nestIrqArb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .pend    (reqIn & enableQ),
    .prioFlat(prioFlat),
    .nestOn  (nestOn),
    .inServ  (inServQ),
    .anyElig (anyElig),
    .selIdx  (selIdx),
    .selPrio (selPrio)
  );

  // retire the most urgent level, or mark the level being entered
  always_comb begin
    inServNext = inServQ;
    if (strb.wrInServ && wrData != '0)
      inServNext = inServQ & (inServQ - LEVELS'(1));
    else if (strb.rdVector && nestOn && anyElig)
      inServNext = inServQ | (LEVELS'(1) << selPrio);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inServQ <= '0;
    else       inServQ <= inServNext;
  end

  always_comb begin
    prioWord = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i / FIELDS_PR == int'(strb.prioReg))
        prioWord[(i % FIELDS_PR) * FIELD_W +: PRIO_W] = prioQ[i];
    end
  end

  always_comb begin
    case (strb.readSel)
      SEL_PRIO:   rdNext = prioWord;
      SEL_CTRL:   rdNext = DATA_W'(ctrlQ);
      SEL_ENABLE: rdNext = DATA_W'(enableQ);
      SEL_INSERV: rdNext = DATA_W'(inServQ);
      SEL_VECTOR: rdNext = anyElig ? DATA_W'(selIdx) : '0;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdDataQ <= '0;
    else if (strb.rdStrobe) rdDataQ <= rdNext;
  end

  assign rdData = rdDataQ;
  assign irqOut = anyElig;

  // R2
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPrio, strb.wrCtrl, strb.wrEnable, strb.wrInServ}));

  // R8
  isr_single_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrInServ && wrData != '0 && inServQ != '0)
      |=> ($countones(inServQ) + 1 == $countones($past(inServQ))));

  // R9
  isr_zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrInServ && wrData == '0) |=> $stable(inServQ));

  // R4
  isr_flat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdVector && !nestOn) |=> $stable(inServQ));

  // R6
  isr_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdVector && nestOn && anyElig) |=> inServQ[$past(selPrio)]);

  // R7
  sel_above_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nestOn && anyElig)
      |-> ((inServQ & ((LEVELS'(2) << selPrio) - LEVELS'(1))) == '0));
endmodule

// File: rtl/nestIrqCtrl.sv
`timescale 1ns/1ps
module nestIrqCtrl
  import nestIrqPkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int FIELDS_PR     = DATA_W / 4,
  localparam int NUM_PRIO_REGS = (NUM_SRC + FIELDS_PR - 1) / FIELDS_PR
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrEn,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic               irqOut
);
  strobes_t strb;

  nestIrqDecode #(.NUM_PRIO_REGS(NUM_PRIO_REGS)) dec_i (
    .addr(addr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .strb(strb)
  );

  nestIrqData #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .reqIn (reqIn),
    .rdData(rdData),
    .irqOut(irqOut)
  );
endmodule

// File: tb/nestIrqCtrl_tb_top.sv
`timescale 1ns/1ps
module nestIrqCtrl_tb_top;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic [NS-1:0] reqIn = '0;
  logic          irqOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int          mPrio [NS];
  logic [NS-1:0] mEn = '0;
  logic [1:0]  mCtrl = '0;
  logic [7:0]  mIsr = '0;
  logic [31:0] mRd = '0;

  always #5 clk = ~clk;

  nestIrqCtrl dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .reqIn(reqIn), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void modelSel(input logic [NS-1:0] rq, output int idx, output int pr);
    int low = 8;
    idx = -1;
    pr = 0;
    for (int l = 7; l >= 0; l--) if (mIsr[l]) low = l;
    for (int i = 0; i < NS; i++) begin
      if (rq[i] && mEn[i]) begin
        int p = mCtrl[0] ? mPrio[i] : 0;
        if (!(mCtrl[0] && p >= low)) begin
          if (idx < 0 || p < pr) begin
            idx = i;
            pr = p;
          end
        end
      end
    end
  endfunction

  function automatic logic [31:0] readVal(int a, logic [NS-1:0] rq);
    logic [31:0] v = '0;
    int idx, pr;
    if (a < 2) begin
      for (int j = 0; j < 8; j++)
        if (a * 8 + j < NS) v[4*j +: 3] = 3'(mPrio[a*8+j]);
    end else if (a == 8) v = 32'(mCtrl);
    else if (a == 9) v = 32'(mEn);
    else if (a == 10) v = 32'(mIsr);
    else if (a == 11) begin
      modelSel(rq, idx, pr);
      v = (idx >= 0) ? 32'(idx) : 32'd0;
    end
    return v;
  endfunction

  task automatic modelEdge(bit w, bit r, int a, logic [31:0] d, logic [NS-1:0] rq);
    int idx, pr;
    modelSel(rq, idx, pr);
    if (r) mRd = readVal(a, rq);
    if (w) begin
      if (a < 2) begin
        for (int j = 0; j < 8; j++)
          if (a * 8 + j < NS) mPrio[a*8+j] = int'(d[4*j +: 3]);
      end else if (a == 8) mCtrl = d[1:0];
      else if (a == 9) mEn = d[NS-1:0];
      else if (a == 10 && d != 0) begin
        for (int l = 0; l < 8; l++) if (mIsr[l]) begin mIsr[l] = 1'b0; break; end
      end
    end
    if (r && a == 11 && mCtrl[0] && idx >= 0) mIsr[pr] = 1'b1;
  endtask

  task automatic cyc(string tag, bit w, bit r, int a, logic [31:0] d, logic [NS-1:0] rq);
    int idx, pr;
    @(negedge clk);
    addr = a[3:0]; wrEn = w; rdEn = r; wrData = d; reqIn = rq;
    #1;
    modelSel(rq, idx, pr);
    check(tag, 32'(irqOut), 32'(idx >= 0), "irqOut");
    @(posedge clk);
    modelEdge(w, r, a, d, rq);
    #1;
    check(tag, rdData, mRd, "rdData");
  endtask

  task automatic rd(string tag, int a, logic [NS-1:0] rq);
    cyc(tag, 0, 1, a, '0, rq);
  endtask

  task automatic wr(string tag, int a, logic [31:0] d, logic [NS-1:0] rq);
    cyc(tag, 1, 0, a, d, rq);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    for (int i = 0; i < NS; i++) mPrio[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", rdData, 32'd0, "rdData after reset");
    check("R1", 32'(irqOut), 32'd0, "irqOut after reset");
    // R1: every register reads zero
    for (int a = 0; a < 12; a++) rd("R1", a, '0);

    // R2: field packing, reserved nibble bits, unmapped locations
    wr("R2", 0, 32'hFFFF_FFFF, '0);
    wr("R2", 1, 32'h1234_5678, '0);
    rd("R2", 0, '0);
    rd("R2", 1, '0);
    wr("R2", 8, 32'hFFFF_FFFE, '0);
    rd("R2", 8, '0);
    wr("R2", 9, 32'hFFFF_FFFF, '0);
    rd("R2", 9, '0);
    rd("R2", 12, '0);
    rd("R2", 2, '0);

    // urgency set: src0..7 = 4,5,6,7,0,1,2,3 ; src8..11 = 3,0,5,6
    wr("R2", 0, 32'h3210_7654, '0);
    wr("R2", 1, 32'h0000_6503, '0);

    // R3 / R4: flat mode (only the stored-but-unused bit is set)
    cyc("R3", 0, 0, 12, '0, 12'h000);
    cyc("R3", 0, 0, 12, '0, 12'h800);
    rd("R4", 11, 12'h800);
    rd("R4", 11, 12'h0A0);
    rd("R4", 10, 12'h0A0);
    wr("R3", 9, 32'h0000_07FF, 12'h800);
    cyc("R3", 0, 0, 12, '0, 12'h800);
    wr("R3", 9, 32'h0000_0FFF, 12'h000);

    // R5 / R6: nesting on
    wr("R5", 8, 32'h1, '0);
    rd("R5", 11, 12'h0C1);
    rd("R6", 10, 12'h0C1);
    // R7: level 2 in service blocks levels 2..7
    cyc("R7", 0, 0, 12, '0, 12'h081);
    cyc("R7", 0, 0, 12, '0, 12'h040);
    rd("R10", 11, 12'h081);
    rd("R10", 10, 12'h081);
    cyc("R7", 0, 0, 12, '0, 12'h020);
    rd("R6", 11, 12'h0A1);
    rd("R6", 10, 12'h000);
    // R8 / R9: unwind
    wr("R8", 10, 32'hFF, 12'h000);
    rd("R8", 10, 12'h000);
    wr("R9", 10, 32'h0, 12'h000);
    rd("R9", 10, 12'h000);
    wr("R8", 10, 32'h1, 12'h000);
    rd("R8", 10, 12'h000);
    // R5: tie at level 0 between src4 and src9
    rd("R5", 11, 12'h210);
    wr("R8", 10, 32'h80, 12'h000);
    // R8: 0x09 -> 0x08 -> 0x00
    rd("R6", 11, 12'h080);
    rd("R6", 11, 12'h010);
    rd("R8", 10, 12'h000);
    wr("R8", 10, 32'hFF, 12'h000);
    rd("R8", 10, 12'h000);
    wr("R8", 10, 32'hFF, 12'h000);
    rd("R8", 10, 12'h000);
    wr("R9", 10, 32'h0, 12'h000);
    rd("R9", 10, 12'h000);

    // R7: random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [NS-1:0] rq = NS'($urandom);
      if (op < 3) rd("R7", 11, rq);
      else if (op < 5) wr("R8", 10, ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom), rq);
      else if (op == 5) wr("R2", $urandom_range(0, 1), $urandom, rq);
      else if (op == 6) wr("R2", 9, $urandom, rq);
      else if (op == 7 && $urandom_range(0, 5) == 0) wr("R3", 8, 32'($urandom_range(0, 3)), rq);
      else rd("R7", $urandom_range(0, 15), rq);
    end
    report();
  end
endmodule